// File: doc/BRIEF.md
# Producer-Consumer Resource Hazard Table

This block keeps two small associative tables that let a producer thread (the binning side) and a consumer thread (the rendering side) share resources safely. Each resource is known only by an opaque 64-bit handle. The block compares handles and never uses them as addresses.

The main table records the resources the consumer is using. Each entry holds the handle, a write attribute and the timestamp of its last use. The producer can ask whether a handle is safe to touch. The answer is a stall flag, given in the same cycle. The producer also inserts entries on the consumer's behalf. When a completion event arrives that asks for render resources to be cleared, the consumer retires every entry whose timestamp is at or below the event's timestamp, all in one cycle. An insertion into a full table is dropped, and a sticky overflow flag records the loss.

The depth-buffer table is separate and works differently. A depth request stalls while its handle is already present. Once the handle is absent, the request enters the table. Depth entries carry no timestamp. Each one is removed by an explicit clear that names its handle.

Top module: `res_hazard_table`

## Requirements
- R1: After reset both tables are empty and `ovf_flag` is 0, so no check or depth request stalls because of an entry left over from before reset.
- R2: A main-table check matches an entry only when all 64 bits of the handles are equal. A handle that differs in any single bit, including bit 63 or bit 0, does not match.
- R3: `chk_stall` is a combinational output of the current cycle. It is 1 exactly when `chk_valid` is 1, a live entry has the same handle, and `chk_write` or the entry's stored write bit is 1. A read checked against a stored read proceeds.
- R4: A check never changes the main table. Checking the same absent handle twice gives no stall both times.
- R5: An insertion of a handle not yet present takes the lowest free slot. Checks see the new entry from the next cycle on, so the table holds exactly `MAIN_SLOTS` distinct entries when full.
- R6: When `ret_valid` is 1, every live entry whose stamp is less than or equal to `ret_stamp` is removed at that clock edge. Entries with a larger stamp stay.
- R7: An insertion that finds no matching entry and no free slot is dropped, and `ovf_flag` is 1 from the next cycle. Filling the last free slot does not set `ovf_flag`.
- R8: `ovf_flag` stays 1 until a cycle with `ovf_clr` at 1. It is 0 from the cycle after that, unless an overflow happens in the same cycle as the clear.
- R9: An insertion whose handle matches a live entry overwrites that entry's write bit and stamp in place. It takes no new slot and cannot overflow.
- R10: Stamps are compared as unsigned 32-bit values. An entry stamped 0x8000_0000 survives a retire at stamp 5 and is removed by a retire at 0xFFFF_FFFF.
- R11: `dep_stall` is 1 while `dep_req_valid` is 1 and either the depth table holds the same handle or the depth table is full. A request that does not stall inserts its handle at that clock edge, so the next request with the same handle stalls.
- R12: A depth clear removes only the entry whose handle equals `dep_clr_handle`. All other depth entries stay, and clearing an absent handle changes nothing.
- R13: The two tables are independent. A handle held in the depth table does not cause a main-table check to stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_valid | input | 1 | Producer hazard check request |
| chk_handle | input | 64 | Handle being checked |
| chk_write | input | 1 | Checked access is a write |
| chk_stall | output | 1 | Check must stall (combinational) |
| ins_valid | input | 1 | Insert a consumer resource |
| ins_handle | input | 64 | Handle to insert |
| ins_write | input | 1 | Inserted access is a write |
| ins_stamp | input | 32 | Timestamp of the inserted use |
| ret_valid | input | 1 | Completion event with render-resource clear |
| ret_stamp | input | 32 | Current timestamp of the completion event |
| ovf_clr | input | 1 | Write-1-to-clear for the overflow flag |
| ovf_flag | output | 1 | Sticky main-table overflow |
| dep_req_valid | input | 1 | Depth resource check-and-insert request |
| dep_req_handle | input | 64 | Depth handle requested |
| dep_stall | output | 1 | Depth request must stall (combinational) |
| dep_clr_valid | input | 1 | Depth resource clear event |
| dep_clr_handle | input | 64 | Depth handle to remove |

## Verification
The bench targets these cases, and names what a faulty design would do in each:

- **Read/read pairing.** The bench checks that a read does not stall against a stored read. A design that ignores the attribute bits would stall there. It also overwrites a read entry in place with a write attribute; a design that appends a duplicate instead would stall on the stale copy or overflow a full table.
- **Retire boundaries.** The bench retires at a stamp equal to an entry's stamp. A strict comparison would leave that entry alive. It also retires at 5 against an entry stamped 0x8000_0000; a signed comparison would remove that entry.
- **Overflow.** The bench fills the table exactly, then overflows it. A design would fail if it sets the flag one slot early, keeps the dropped handle, or lets the flag decay before it is cleared.
- **Depth table.** The bench checks the full-table stall, and it clears one handle among several. A design that clears by slot or clears all entries would release the wrong depth handles.

// File: rtl/res_hazard_pkg.sv
package res_hazard_pkg;

    localparam int HANDLE_W = 64;
    localparam int STAMP_W  = 32;

    typedef logic [HANDLE_W-1:0] handle_t;
    typedef logic [STAMP_W-1:0]  stamp_t;

    // main table slot: occupancy, opaque handle, write attribute, last-use stamp
    typedef struct packed {
        logic    live;
        handle_t handle;
        logic    wr;
        stamp_t  stamp;
    } main_ent_t;

    // depth table slot: no stamp, removal is by handle only
    typedef struct packed {
        logic    live;
        handle_t handle;
    } dep_ent_t;

endpackage

// File: rtl/rh_slot_pick.sv
// Lowest-index picker: reports whether any bit is set and the index of the lowest one.
module rh_slot_pick #(
    parameter  int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  cand,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |cand;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/rh_main_table.sv
module rh_main_table
    import res_hazard_pkg::*;
#(
    parameter  int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    chk_valid,
    input  handle_t chk_handle,
    input  logic    chk_write,
    output logic    chk_stall,
    input  logic    ins_valid,
    input  handle_t ins_handle,
    input  logic    ins_write,
    input  stamp_t  ins_stamp,
    input  logic    ret_valid,
    input  stamp_t  ret_stamp,
    input  logic    ovf_clr,
    output logic    ovf_flag
);
    typedef struct packed {
        main_ent_t [N-1:0] ent;
        logic              ovf;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0]  live_q;
    logic [N-1:0]  chk_hit;
    logic [N-1:0]  chk_conflict;
    logic [N-1:0]  ret_kill;
    logic [N-1:0]  live_after;
    logic [N-1:0]  ins_hit;
    logic          hit_any, free_any;
    logic [IW-1:0] hit_idx, free_idx;
    logic          ovf_set;

    // per-slot compare bank
    for (genvar i = 0; i < N; i++) begin : g_slot
        assign live_q[i]       = st_q.ent[i].live;
        assign chk_hit[i]      = st_q.ent[i].live && (st_q.ent[i].handle == chk_handle);
        assign chk_conflict[i] = chk_hit[i] && (chk_write || st_q.ent[i].wr);
        assign ret_kill[i]     = ret_valid && st_q.ent[i].live
                                 && (st_q.ent[i].stamp <= ret_stamp);
        assign live_after[i]   = st_q.ent[i].live && !ret_kill[i];
        assign ins_hit[i]      = live_after[i] && (st_q.ent[i].handle == ins_handle);
    end

    assign chk_stall = chk_valid && (|chk_conflict);
    assign ovf_flag  = st_q.ovf;

    rh_slot_pick #(.N(N)) u_hit_pick (
        .cand (ins_hit),
        .any  (hit_any),
        .idx  (hit_idx)
    );

    rh_slot_pick #(.N(N)) u_free_pick (
        .cand (~live_after),
        .any  (free_any),
        .idx  (free_idx)
    );

    always_comb begin
        st_d    = st_q;
        ovf_set = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (ret_kill[i]) st_d.ent[i].live = 1'b0;
        end
        if (ins_valid) begin
            if (hit_any) begin
                st_d.ent[hit_idx].wr    = ins_write;
                st_d.ent[hit_idx].stamp = ins_stamp;
            end else if (free_any) begin
                st_d.ent[free_idx] = '{live: 1'b1, handle: ins_handle,
                                       wr: ins_write, stamp: ins_stamp};
            end else begin
                ovf_set = 1'b1;
            end
        end
        st_d.ovf = ovf_set || (st_q.ovf && !ovf_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> $countones(chk_hit) <= 1); // R9
    AST_CHECK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_valid && !ret_valid) |=> $stable(st_q.ent)); // R4
    AST_RETIRE_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !ins_valid) |=> ((live_q & ~$past(live_q)) == '0)); // R6
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ret_valid && (&live_q) && !(|ins_hit)) |=> (st_q.ovf && $stable(live_q))); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !ovf_clr) |=> st_q.ovf); // R8
endmodule

// File: rtl/rh_depth_table.sv
module rh_depth_table
    import res_hazard_pkg::*;
#(
    parameter  int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  handle_t req_handle,
    output logic    req_stall,
    input  logic    clr_valid,
    input  handle_t clr_handle
);
    typedef struct packed {
        dep_ent_t [N-1:0] ent;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0]  live_q;
    logic [N-1:0]  req_hit;
    logic [N-1:0]  clr_hit;
    logic          free_any;
    logic [IW-1:0] free_idx;
    logic          grant;

    for (genvar i = 0; i < N; i++) begin : g_slot
        assign live_q[i]  = st_q.ent[i].live;
        assign req_hit[i] = st_q.ent[i].live && (st_q.ent[i].handle == req_handle);
        assign clr_hit[i] = clr_valid && st_q.ent[i].live
                            && (st_q.ent[i].handle == clr_handle);
    end

    // stall on a present handle, or when there is nowhere to put it
    assign req_stall = req_valid && ((|req_hit) || !free_any);
    assign grant     = req_valid && !req_stall;

    rh_slot_pick #(.N(N)) u_free_pick (
        .cand (~live_q),
        .any  (free_any),
        .idx  (free_idx)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (clr_hit[i]) st_d.ent[i].live = 1'b0;
        end
        if (grant) begin
            st_d.ent[free_idx] = '{live: 1'b1, handle: req_handle};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_DEP_STALL_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_stall && !clr_valid) |=> $stable(live_q)); // R11
    AST_DEP_GRANT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !clr_valid) |=> ($countones(live_q) == $countones($past(live_q)) + 1)); // R11
    AST_DEP_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && !req_valid) |=> ($countones($past(live_q) & ~live_q) <= 1)); // R12
    AST_DEP_CLEAR_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && !req_valid) |=> ((live_q & ~$past(live_q)) == '0)); // R12
endmodule

// File: rtl/res_hazard_table.sv
module res_hazard_table
    import res_hazard_pkg::*;
#(
    parameter int MAIN_SLOTS  = 8,
    parameter int DEPTH_SLOTS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chk_valid,
    input  logic [HANDLE_W-1:0] chk_handle,
    input  logic                chk_write,
    output logic                chk_stall,
    input  logic                ins_valid,
    input  logic [HANDLE_W-1:0] ins_handle,
    input  logic                ins_write,
    input  logic [STAMP_W-1:0]  ins_stamp,
    input  logic                ret_valid,
    input  logic [STAMP_W-1:0]  ret_stamp,
    input  logic                ovf_clr,
    output logic                ovf_flag,
    input  logic                dep_req_valid,
    input  logic [HANDLE_W-1:0] dep_req_handle,
    output logic                dep_stall,
    input  logic                dep_clr_valid,
    input  logic [HANDLE_W-1:0] dep_clr_handle
);
    rh_main_table #(.N(MAIN_SLOTS)) u_main (
        .clk        (clk),
        .rst_n      (rst_n),
        .chk_valid  (chk_valid),
        .chk_handle (chk_handle),
        .chk_write  (chk_write),
        .chk_stall  (chk_stall),
        .ins_valid  (ins_valid),
        .ins_handle (ins_handle),
        .ins_write  (ins_write),
        .ins_stamp  (ins_stamp),
        .ret_valid  (ret_valid),
        .ret_stamp  (ret_stamp),
        .ovf_clr    (ovf_clr),
        .ovf_flag   (ovf_flag)
    );

    rh_depth_table #(.N(DEPTH_SLOTS)) u_depth (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (dep_req_valid),
        .req_handle (dep_req_handle),
        .req_stall  (dep_stall),
        .clr_valid  (dep_clr_valid),
        .clr_handle (dep_clr_handle)
    );
endmodule

// File: tb/res_hazard_table_test.sv
module res_hazard_table_test;

    localparam int OP_IDLE = 0, OP_CHK = 1, OP_INS = 2, OP_RET = 3,
                   OP_DREQ = 4, OP_DCLR = 5, OP_OCLR = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_valid, chk_write, ins_valid, ins_write, ret_valid, ovf_clr;
    logic        dep_req_valid, dep_clr_valid;
    logic [63:0] chk_handle, ins_handle, dep_req_handle, dep_clr_handle;
    logic [31:0] ins_stamp, ret_stamp;
    logic        chk_stall, ovf_flag, dep_stall;

    int n_run = 0;
    int n_fail = 0;
    logic s_chk, s_dep, s_ovf;

    always #2 clk = ~clk;

    res_hazard_table uut (
        .clk(clk), .rst_n(rst_n),
        .chk_valid(chk_valid), .chk_handle(chk_handle), .chk_write(chk_write),
        .chk_stall(chk_stall),
        .ins_valid(ins_valid), .ins_handle(ins_handle), .ins_write(ins_write),
        .ins_stamp(ins_stamp),
        .ret_valid(ret_valid), .ret_stamp(ret_stamp),
        .ovf_clr(ovf_clr), .ovf_flag(ovf_flag),
        .dep_req_valid(dep_req_valid), .dep_req_handle(dep_req_handle),
        .dep_stall(dep_stall),
        .dep_clr_valid(dep_clr_valid), .dep_clr_handle(dep_clr_handle)
    );

    function automatic logic [63:0] hnd(input int id);
        return {8'hC3, 24'h5A0F00, 24'h0, 8'(id)};
    endfunction

    typedef struct packed {
        logic [2:0]  op;
        logic [7:0]  id;
        logic        wr;
        logic [31:0] ts;
        logic        exp_stall;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VEC [14] = '{
        '{3'd1, 8'd1, 1'b0, 32'd0,  1'b0, 4'd1},   // R1 empty after reset
        '{3'd2, 8'd1, 1'b0, 32'd10, 1'b0, 4'd5},   // R5 insert h1 read
        '{3'd1, 8'd1, 1'b0, 32'd0,  1'b0, 4'd3},   // R3 read vs read
        '{3'd1, 8'd1, 1'b1, 32'd0,  1'b1, 4'd3},   // R3 write vs read
        '{3'd2, 8'd2, 1'b1, 32'd20, 1'b0, 4'd5},   // R5 insert h2 write
        '{3'd1, 8'd2, 1'b0, 32'd0,  1'b1, 4'd3},   // R3 read vs write
        '{3'd1, 8'd3, 1'b1, 32'd0,  1'b0, 4'd2},   // R2 absent handle
        '{3'd2, 8'd1, 1'b1, 32'd30, 1'b0, 4'd9},   // R9 update h1 to write
        '{3'd1, 8'd1, 1'b0, 32'd0,  1'b1, 4'd9},   // R9 new attribute seen
        '{3'd3, 8'd0, 1'b0, 32'd25, 1'b0, 4'd6},   // R6 retire <=25
        '{3'd1, 8'd2, 1'b1, 32'd0,  1'b0, 4'd6},   // R6 h2 gone
        '{3'd1, 8'd1, 1'b0, 32'd0,  1'b1, 4'd6},   // R6 h1 (30) kept
        '{3'd3, 8'd0, 1'b0, 32'd30, 1'b0, 4'd6},   // R6 retire equal stamp
        '{3'd1, 8'd1, 1'b1, 32'd0,  1'b0, 4'd6}    // R6 h1 gone
    };

    task automatic step(input int op, input logic [63:0] h, input logic w,
                        input logic [31:0] ts);
        @(negedge clk);
        chk_valid = 0; chk_write = 0; chk_handle = '0;
        ins_valid = 0; ins_write = 0; ins_handle = '0; ins_stamp = '0;
        ret_valid = 0; ret_stamp = '0; ovf_clr = 0;
        dep_req_valid = 0; dep_req_handle = '0; dep_clr_valid = 0; dep_clr_handle = '0;
        case (op)
            OP_CHK:  begin chk_valid = 1; chk_handle = h; chk_write = w; end
            OP_INS:  begin ins_valid = 1; ins_handle = h; ins_write = w; ins_stamp = ts; end
            OP_RET:  begin ret_valid = 1; ret_stamp = ts; end
            OP_DREQ: begin dep_req_valid = 1; dep_req_handle = h; end
            OP_DCLR: begin dep_clr_valid = 1; dep_clr_handle = h; end
            OP_OCLR: ovf_clr = 1;
            default: ;
        endcase
        #1;
        s_chk = chk_stall; s_dep = dep_stall; s_ovf = ovf_flag;
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        step(OP_IDLE, '0, 0, 0);
        step(OP_IDLE, '0, 0, 0);
        rst_n = 1'b1;
        step(OP_IDLE, '0, 0, 0);
        check("R1 overflow clear after reset", s_ovf, 1'b0);

        for (int k = 0; k < 14; k++) begin
            step(int'(VEC[k].op), hnd(int'(VEC[k].id)), VEC[k].wr, VEC[k].ts);
            if (int'(VEC[k].op) == OP_CHK)
                check($sformatf("R%0d vector %0d stall", VEC[k].req, k), s_chk, VEC[k].exp_stall);
        end

        // R2: full 64-bit compare
        step(OP_INS, hnd(1), 1, 5);
        step(OP_CHK, hnd(1) ^ 64'h8000_0000_0000_0000, 1, 0);
        check("R2 bit63 differs", s_chk, 1'b0);
        step(OP_CHK, hnd(1) ^ 64'h1, 1, 0);
        check("R2 bit0 differs", s_chk, 1'b0);
        step(OP_CHK, hnd(1), 0, 0);
        check("R2 exact match stalls", s_chk, 1'b1);
        step(OP_IDLE, hnd(1), 0, 0);
        check("R3 no request no stall", s_chk, 1'b0);
        step(OP_RET, '0, 0, 5);

        // R4: checks never insert
        step(OP_CHK, hnd(30), 1, 0);
        check("R4 first check of absent", s_chk, 1'b0);
        step(OP_CHK, hnd(30), 1, 0);
        check("R4 second check still absent", s_chk, 1'b0);

        // R5/R7/R9: fill, update in place, overflow
        for (int i = 0; i < 8; i++) step(OP_INS, hnd(10 + i), 1, 32'(i + 1));
        step(OP_CHK, hnd(17), 1, 0);
        check("R5 last slot filled", s_chk, 1'b1);
        check("R7 no overflow at exactly full", s_ovf, 1'b0);
        step(OP_INS, hnd(10), 0, 50);
        step(OP_CHK, hnd(10), 0, 0);
        check("R9 in-place update to read", s_chk, 1'b0);
        check("R9 update on full table no overflow", s_ovf, 1'b0);
        step(OP_INS, hnd(18), 1, 9);
        step(OP_CHK, hnd(18), 1, 0);
        check("R7 dropped handle absent", s_chk, 1'b0);
        check("R7 overflow set", s_ovf, 1'b1);
        step(OP_RET, '0, 0, 8);
        step(OP_CHK, hnd(10), 1, 0);
        check("R6 stamp 50 kept", s_chk, 1'b1);
        step(OP_CHK, hnd(11), 1, 0);
        check("R6 stamp 2 removed", s_chk, 1'b0);
        step(OP_CHK, hnd(17), 1, 0);
        check("R6 stamp 8 removed", s_chk, 1'b0);
        check("R8 overflow sticky", s_ovf, 1'b1);
        step(OP_OCLR, '0, 0, 0);
        step(OP_IDLE, '0, 0, 0);
        check("R8 overflow cleared", s_ovf, 1'b0);

        // R10: unsigned stamps
        step(OP_INS, hnd(20), 1, 32'h8000_0000);
        step(OP_RET, '0, 0, 5);
        step(OP_CHK, hnd(20), 0, 0);
        check("R10 large stamp survives", s_chk, 1'b1);
        step(OP_RET, '0, 0, 32'hFFFF_FFFF);
        step(OP_CHK, hnd(20), 0, 0);
        check("R10 max stamp retires all", s_chk, 1'b0);
        step(OP_CHK, hnd(10), 1, 0);
        check("R6 stamp 50 removed by max", s_chk, 1'b0);

        // R11/R12/R13: depth table
        step(OP_DREQ, hnd(1), 0, 0);
        check("R1 depth empty grants", s_dep, 1'b0);
        step(OP_DREQ, hnd(1), 0, 0);
        check("R11 present handle stalls", s_dep, 1'b1);
        step(OP_CHK, hnd(1), 1, 0);
        check("R13 depth entry not in main", s_chk, 1'b0);
        step(OP_DREQ, hnd(2), 0, 0);
        check("R11 grant h2", s_dep, 1'b0);
        step(OP_DREQ, hnd(3), 0, 0);
        check("R11 grant h3", s_dep, 1'b0);
        step(OP_DREQ, hnd(4), 0, 0);
        check("R11 grant h4", s_dep, 1'b0);
        step(OP_DREQ, hnd(5), 0, 0);
        check("R11 full table stalls", s_dep, 1'b1);
        step(OP_DCLR, hnd(9), 0, 0);
        step(OP_DREQ, hnd(5), 0, 0);
        check("R12 absent clear no effect", s_dep, 1'b1);
        step(OP_DCLR, hnd(2), 0, 0);
        step(OP_DREQ, hnd(1), 0, 0);
        check("R12 h1 kept", s_dep, 1'b1);
        step(OP_DREQ, hnd(3), 0, 0);
        check("R12 h3 kept", s_dep, 1'b1);
        step(OP_DREQ, hnd(2), 0, 0);
        check("R12 h2 freed and granted", s_dep, 1'b0);
        step(OP_DREQ, hnd(2), 0, 0);
        check("R11 h2 present again", s_dep, 1'b1);
        step(OP_IDLE, '0, 0, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule